// File: doc/BRIEF.md
# Multiplexed Bus Memory and I/O Target

This block is the peripheral end of a narrow, byte-serial bus driven by a small processor core. The core labels each cycle with a phase code and moves one byte per cycle: first a request code, then the high and low address bytes, then a data phase. The target latches the request code and the address. In the data phase it serves the request from an on-chip program memory, an on-chip data memory, a queue of input bytes or an output byte stream, and it answers with a one-cycle done pulse.

After reset the target sweeps every data memory location to zero, one location per cycle. During the sweep it holds the core's enable low. When the sweep finishes it raises enable and ready together. The program memory is filled through a separate load port before the core runs. Input bytes are pushed into a small queue from outside. Output bytes appear as a one-cycle strobe with the byte beside it.

Top module: `mux_bus_target`

## Requirements
- R1: While reset is held and on the first cycle after it, `done`, `out_valid`, `cpu_en` and `ready` are all 0.
- R2: After reset is released, `ready` and `cpu_en` stay 0 for exactly 2^DATA_AW clock edges and are 1 from then on. Every data memory location reads back as 0 afterwards. No `done` occurs while `ready` is 0.
- R3: Phase 1 latches `cpu_dout[2:0]` as the request code. Phase 2 latches the address high byte and phase 3 latches the address low byte. Only the low PROG_AW (program) or DATA_AW (data) address bits select a location, so addresses differing only above those bits reach the same byte.
- R4: Request code 3'b010 (read program) returns the addressed program byte on `cpu_din`. `done` is 1 on the first clock edge that samples phase 4.
- R5: Request code 3'b100 (read data) returns the addressed data byte on `cpu_din`, with the same latency as R4.
- R6: Request code 3'b101 (write data) stores `cpu_dout` at the addressed data location and raises `done` with the same latency as R4. A later read returns the stored byte.
- R7: Request code 3'b110 (read I/O) returns the oldest queued input byte with `done` and removes it from the queue. Bytes come out in push order, also across pointer wrap.
- R8: A read I/O request with an empty queue keeps `done` at 0. If a byte is pushed on edge E, `done` is 1 after edge E+1 and carries that byte.
- R9: Request code 3'b111 (write I/O) raises `out_valid` for one cycle together with `done`, with `out_byte` equal to the data-phase `cpu_dout`.
- R10: `done` is high for exactly one cycle per data phase. It does not rise again until the phase code has left 4 and returned. Phase codes: 0 idle, 1 request code, 2 address high, 3 address low, 4 data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | 3 | Bus phase code from the core |
| cpu_dout | input | 8 | Byte driven by the core |
| cpu_din | output | 8 | Byte returned to the core |
| done | output | 1 | One-cycle completion pulse in the data phase |
| cpu_en | output | 1 | Enable for the core, low during the clear sweep |
| ready | output | 1 | Clear sweep finished |
| ld_we | input | 1 | Program memory load strobe |
| ld_addr | input | PROG_AW | Program memory load address |
| ld_data | input | 8 | Program memory load byte |
| in_push | input | 1 | Push a byte into the input queue |
| in_byte | input | 8 | Byte to push |
| in_full | output | 1 | Input queue full, push ignored |
| out_valid | output | 1 | Output stream strobe |
| out_byte | output | 8 | Output stream byte |

## Verification
A wrong latched request code or address shows up at the port as a wrong `cpu_din` value or a misplaced write. It is visible in the same data phase, or on the next read of the affected location. A stuck served flag either repeats `done` within one cycle or withholds it for a whole transaction. A broken queue pointer shows up as a byte out of order within one pop, or after the pointers wrap once. A miscounted sweep moves the rising edge of `ready`, which the bench measures to the exact clock edge.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_CODE = 3'd1,
        PH_AHI  = 3'd2,
        PH_ALO  = 3'd3,
        PH_DATA = 3'd4
    } phase_e;

    typedef enum logic [2:0] {
        RQ_NONE    = 3'b000,
        RQ_RD_PROG = 3'b010,
        RQ_RD_DATA = 3'b100,
        RQ_WR_DATA = 3'b101,
        RQ_RD_IO   = 3'b110,
        RQ_WR_IO   = 3'b111
    } req_e;
endpackage

// File: rtl/mbt_ram.sv
module mbt_ram #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mbt_fifo.sv
module mbt_fifo #(
    parameter int AW = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  logic [7:0] wdata,
    input  logic       pop,
    output logic [7:0] rdata,
    output logic       empty,
    output logic       full
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } fifo_t;

    fifo_t      q, d;
    logic       do_push, do_pop;
    logic [7:0] slot [DEPTH];

    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == (AW+1)'(DEPTH));
    assign rdata = slot[q.rp];

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) d.wp = q.wp + 1'b1;
        if (do_pop)  d.rp = q.rp + 1'b1;
        d.cnt = q.cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) slot[q.wp] <= wdata;
    end
endmodule

// File: rtl/mux_bus_target.sv
module mux_bus_target
    import mbt_pkg::*;
#(
    parameter int PROG_AW = 6,
    parameter int DATA_AW = 5,
    parameter int QUEUE_AW = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         phase,
    input  logic [7:0]         cpu_dout,
    output logic [7:0]         cpu_din,
    output logic               done,
    output logic               cpu_en,
    output logic               ready,
    input  logic               ld_we,
    input  logic [PROG_AW-1:0] ld_addr,
    input  logic [7:0]         ld_data,
    input  logic               in_push,
    input  logic [7:0]         in_byte,
    output logic               in_full,
    output logic               out_valid,
    output logic [7:0]         out_byte
);
    typedef struct packed {
        logic               clr;
        logic [DATA_AW-1:0] sweep;
        logic [2:0]         code;
        logic [15:0]        addr;
        logic               served;
        logic               done;
        logic [7:0]         din;
        logic               ovalid;
        logic [7:0]         obyte;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{clr: 1'b1, default: '0};

    ctl_t               q, d;
    phase_e             ph;
    logic [7:0]         prog_rd, data_rd, q_head;
    logic               q_empty, q_pop;
    logic               dwe;
    logic [DATA_AW-1:0] dwaddr;
    logic [7:0]         dwdata;
    logic               serve;

    mbt_ram #(.AW(PROG_AW)) u_prog (
        .clk   (clk),
        .we    (ld_we),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (q.addr[PROG_AW-1:0]),
        .rdata (prog_rd)
    );

    mbt_ram #(.AW(DATA_AW)) u_data (
        .clk   (clk),
        .we    (dwe),
        .waddr (dwaddr),
        .wdata (dwdata),
        .raddr (q.addr[DATA_AW-1:0]),
        .rdata (data_rd)
    );

    mbt_fifo #(.AW(QUEUE_AW)) u_inq (
        .clk   (clk),
        .rst   (rst),
        .push  (in_push),
        .wdata (in_byte),
        .pop   (q_pop),
        .rdata (q_head),
        .empty (q_empty),
        .full  (in_full)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.ovalid = 1'b0;
        ph       = phase_e'(phase);
        dwe      = 1'b0;
        dwaddr   = q.addr[DATA_AW-1:0];
        dwdata   = cpu_dout;
        q_pop    = 1'b0;
        serve    = 1'b0;
        if (q.clr) begin
            dwe     = 1'b1;
            dwaddr  = q.sweep;
            dwdata  = 8'h00;
            d.sweep = q.sweep + 1'b1;
            if (q.sweep == '1) d.clr = 1'b0;
        end else begin
            if (ph != PH_DATA) d.served = 1'b0;
            case (ph)
                PH_CODE: d.code       = cpu_dout[2:0];
                PH_AHI:  d.addr[15:8] = cpu_dout;
                PH_ALO:  d.addr[7:0]  = cpu_dout;
                PH_DATA: begin
                    if (!q.served) begin
                        serve = 1'b1;
                        case (req_e'(q.code))
                            RQ_RD_PROG: d.din = prog_rd;
                            RQ_RD_DATA: d.din = data_rd;
                            RQ_WR_DATA: dwe = 1'b1;
                            RQ_RD_IO: begin
                                if (q_empty) begin
                                    serve = 1'b0;
                                end else begin
                                    d.din = q_head;
                                    q_pop = 1'b1;
                                end
                            end
                            RQ_WR_IO: begin
                                d.ovalid = 1'b1;
                                d.obyte  = cpu_dout;
                            end
                            default: ;
                        endcase
                        if (serve) begin
                            d.served = 1'b1;
                            d.done   = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= CTL_RESET;
        else     q <= d;
    end

    assign cpu_din   = q.din;
    assign done      = q.done;
    assign ready     = !q.clr;
    assign cpu_en    = !q.clr;
    assign out_valid = q.ovalid;
    assign out_byte  = q.obyte;
endmodule

// File: rtl/mux_bus_target_chk.sv
module mux_bus_target_chk #(
    parameter int DAW = 5
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] phase,
    input logic       done,
    input logic       ready,
    input logic       out_valid
);
    logic [DAW+1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst)         wait_cnt <= '0;
        else if (!ready) wait_cnt <= wait_cnt + 1'b1;
    end

    AST_SWEEP_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> wait_cnt == (DAW+2)'(1 << DAW)); // R2

    AST_READY_STAYS: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready); // R2

    AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !done); // R2

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_DONE_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(phase) == 3'd4); // R10

    AST_OUT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> done); // R9
endmodule

bind mux_bus_target mux_bus_target_chk #(.DAW(DATA_AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .done      (done),
    .ready     (ready),
    .out_valid (out_valid)
);

// File: tb/mux_bus_target_test.sv
module mux_bus_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int PAW = 6;
    localparam int DAW = 5;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [2:0]     phase = 3'd0;
    logic [7:0]     cpu_dout = 8'h00;
    logic [7:0]     cpu_din;
    logic           done, cpu_en, ready, in_full, out_valid;
    logic           ld_we = 1'b0;
    logic [PAW-1:0] ld_addr = '0;
    logic [7:0]     ld_data = 8'h00;
    logic           in_push = 1'b0;
    logic [7:0]     in_byte = 8'h00;
    logic [7:0]     out_byte;

    int checks = 0;
    int errors = 0;

    mux_bus_target #(.PROG_AW(PAW), .DATA_AW(DAW), .QUEUE_AW(2)) uut (
        .clk(clk), .rst(rst), .phase(phase), .cpu_dout(cpu_dout), .cpu_din(cpu_din),
        .done(done), .cpu_en(cpu_en), .ready(ready), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data), .in_push(in_push), .in_byte(in_byte), .in_full(in_full),
        .out_valid(out_valid), .out_byte(out_byte)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic xfer(input logic [2:0] code, input logic [15:0] a, input logic [7:0] w,
                        output logic [7:0] r, output int lat,
                        output logic ov, output logic [7:0] ob);
        @(negedge clk); phase = 3'd1; cpu_dout = {5'b10110, code};
        @(negedge clk); phase = 3'd2; cpu_dout = a[15:8];
        @(negedge clk); phase = 3'd3; cpu_dout = a[7:0];
        @(negedge clk); phase = 3'd4; cpu_dout = w;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!done && lat < 40);
        r = cpu_din; ov = out_valid; ob = out_byte;
        @(negedge clk);
        check(!done, "R10 done repeated", int'(done), 0);
        check(!out_valid, "R9 strobe width", int'(out_valid), 0);
        phase = 3'd0;
    endtask

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk); in_push = 1'b1; in_byte = b;
        @(negedge clk); in_push = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [7:0] r, ob;
        logic       ov;
        int         lat;
        int         n;

        for (int i = 0; i < (1 << PAW); i++) begin
            @(negedge clk);
            ld_we = 1'b1; ld_addr = PAW'(i); ld_data = 8'((i * 7 + 3) ^ 8'h5a);
        end
        @(negedge clk); ld_we = 1'b0;
        repeat (2) @(negedge clk);
        // R1 reset state
        check(!done && !out_valid && !cpu_en && !ready, "R1 reset outputs",
              {done, out_valid, cpu_en, ready}, 0);
        rst = 1'b0;
        n = 0;
        @(negedge clk); n++;
        check(!done && !out_valid && !cpu_en && !ready, "R1 first cycle",
              {done, out_valid, cpu_en, ready}, 0);
        while (!ready && n < 200) begin
            @(negedge clk); n++;
        end
        check(n == (1 << DAW), "R2 sweep length", n, 1 << DAW);
        check(cpu_en, "R2 enable after sweep", int'(cpu_en), 1);

        // R2 data memory is zero
        for (int i = 0; i < (1 << DAW); i++) begin
            xfer(3'b100, 16'(i), 8'h00, r, lat, ov, ob);
            check(r == 8'h00, "R2 cleared location", r, 0);
            check(lat == 1, "R5 latency", lat, 1);
        end

        // R4 program memory sweep
        for (int i = 0; i < (1 << PAW); i++) begin
            xfer(3'b010, 16'(i), 8'h00, r, lat, ov, ob);
            check(r == 8'((i * 7 + 3) ^ 8'h5a), "R4 program byte", r, 8'((i * 7 + 3) ^ 8'h5a));
            check(lat == 1, "R4 latency", lat, 1);
        end

        // R6 write data, R5 read back
        for (int i = 0; i < (1 << DAW); i++) begin
            xfer(3'b101, 16'(i), 8'(i * 13 + 5), r, lat, ov, ob);
            check(lat == 1, "R6 write latency", lat, 1);
        end
        for (int i = 0; i < (1 << DAW); i++) begin
            xfer(3'b100, 16'(i), 8'h00, r, lat, ov, ob);
            check(r == 8'(i * 13 + 5), "R6 read back", r, 8'(i * 13 + 5));
        end

        // R3 upper address bits ignored
        for (int i = 0; i < 8; i++) begin
            xfer(3'b100, 16'(16'h3700 | (i << DAW) | i), 8'h00, r, lat, ov, ob);
            check(r == 8'(i * 13 + 5), "R3 data alias", r, 8'(i * 13 + 5));
            xfer(3'b010, 16'(16'hc100 | (3 << PAW) | i), 8'h00, r, lat, ov, ob);
            check(r == 8'((i * 7 + 3) ^ 8'h5a), "R3 program alias", r, 8'((i * 7 + 3) ^ 8'h5a));
        end

        // R7 queue order across several wraps
        for (int round = 0; round < 4; round++) begin
            for (int k = 0; k < 3; k++) push_byte(8'(round * 40 + k * 9 + 1));
            for (int k = 0; k < 3; k++) begin
                xfer(3'b110, 16'h0000, 8'h00, r, lat, ov, ob);
                check(r == 8'(round * 40 + k * 9 + 1), "R7 queue order", r, 8'(round * 40 + k * 9 + 1));
                check(lat == 1, "R7 latency", lat, 1);
            end
        end

        // R8 empty queue withholds done
        fork
            xfer(3'b110, 16'h0000, 8'h00, r, lat, ov, ob);
            begin
                repeat (8) @(negedge clk);
                in_push = 1'b1; in_byte = 8'hc3;
                @(negedge clk); in_push = 1'b0;
            end
        join
        check(lat == 6, "R8 done after push", lat, 6);
        check(r == 8'hc3, "R8 byte after wait", r, 8'hc3);

        // R9 write I/O strobe
        for (int i = 0; i < 6; i++) begin
            xfer(3'b111, 16'h0000, 8'(8'h81 + i * 17), r, lat, ov, ob);
            check(ov == 1'b1, "R9 strobe", int'(ov), 1);
            check(ob == 8'(8'h81 + i * 17), "R9 byte", ob, 8'(8'h81 + i * 17));
            check(lat == 1, "R9 latency", lat, 1);
        end

        // R10 long data phase gives a single pulse
        @(negedge clk); phase = 3'd1; cpu_dout = 8'h04;
        @(negedge clk); phase = 3'd4;
        n = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (done) n++;
        end
        check(n == 1, "R10 pulses per phase", n, 1);
        phase = 3'd0;
        @(negedge clk);
        finish_run();
    end
endmodule